// File: doc/BRIEF.md
# Flash page programming controller

This block sits between a CPU register port and an on-chip code memory and manages every write into that memory. Software first opens a write window by setting a latch-map bit in a small control register, then stores between one and 128 bytes into a page-sized buffer of column latches. Each latch write carries a 15-bit address. The low seven bits pick the byte inside a page, and the upper eight bits pick the page that is to be programmed.

A launch needs two consecutive accepted control writes whose key field holds 5h and then Ah. After a launch the block runs a timed pass in two phases. The erase phase sets every loaded location to FFh. The program phase then writes the latched values. Only the bytes that were loaded are touched, so no separate page erase is needed. A mode field selects where the pass lands: the main array, a 128-byte extra row, or the upper nibble of a one-byte security space. A busy output and an idle-request output stay high for the whole pass, so the CPU can hold off instruction fetches. A combinational read port lets the contents of all three spaces be observed.

The main array is a behavioural model of `NUM_PAGES` pages of 128 bytes. The page field of an address is reduced modulo `NUM_PAGES`.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, busy and idle_req are 0, every byte of the main array and of the extra row reads FFh, and the security byte reads {4'hF, SEC_LOW}.
- R2: A data write is stored in the latches only while the latch-map bit (control bit 2) is 1 and busy is 0. Any other data write leaves the memory unchanged after later launches.
- R3: A launch happens only on an accepted control write whose key (control bits 6:3) is Ah, when the accepted control write just before it had key 5h. The sequences A alone and 5, other, A do not launch.
- R4: A launch whose mode field (control bits 1:0) is 11 does nothing: busy stays 0, and the loaded latches remain valid.
- R5: busy and idle_req rise one cycle after the launching control write and stay high for exactly ERASE_CYCLES + PROG_CYCLES cycles.
- R6: ERASE_CYCLES cycles after launch, every loaded location reads FFh. Locations that were not loaded keep their value.
- R7: At the end of the pass, every loaded location holds its latched value. Other bytes of the page, and other pages, are unchanged.
- R8: The pass targets the page given by address bits 14:7 of the last latch write, modulo NUM_PAGES. Address bits 6:0 give the byte within that page.
- R9: Mode 01 writes the loaded bytes into the extra row at their offsets and leaves the main array untouched.
- R10: Mode 10 erases and then programs only the upper nibble of the security byte, taking it from latch offset 0. The lower nibble always reads SEC_LOW.
- R11: All latch valid bits clear when a pass completes, so a later launch with no new loads changes nothing. A repeated write to the same offset keeps the last value.
- R12: Control writes made while busy is 1 are ignored. They do not start a new pass, and they change neither the latch-map bit nor the key state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control write data: key [6:3], latch-map [2], mode [1:0] |
| dat_we | input | 1 | Data-space write strobe |
| dat_addr | input | 15 | Data write address: page [14:7], byte [6:0] |
| dat_wdata | input | 8 | Data write byte |
| rd_space | input | 2 | Read space select: 00 main, 01 extra row, 10 security |
| rd_addr | input | 15 | Read address, same split as dat_addr |
| rd_data | output | 8 | Combinational read data (00h for space 11) |
| busy | output | 1 | High while an erase/program pass runs |
| idle_req | output | 1 | Request for the CPU to idle during the pass |

## Verification
busy and idle_req change on the clock edge that follows the launching control write. Erased bytes appear ERASE_CYCLES edges after that edge, and programmed bytes appear, together with the fall of busy, after ERASE_CYCLES + PROG_CYCLES edges. The read port is combinational, so a value can be seen in the cycle it is stored. The bench advances a behavioural model on each rising edge and compares busy, idle_req and the currently addressed byte 3 ns after the edge. Directed checks count cycles from the launch to reach the erase-only window and the end of the pass.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    localparam int PAGE_BYTES = 128;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int PAGE_W     = 8;
    localparam int ADDR_W     = PAGE_W + OFF_W;
    localparam int KEY_W      = 4;
    localparam int CTRL_W     = KEY_W + 3;

    localparam logic [KEY_W-1:0] KEY_ARM  = 4'h5;
    localparam logic [KEY_W-1:0] KEY_FIRE = 4'hA;

    // target memory space
    typedef enum logic [1:0] {
        SPC_USER  = 2'b00,
        SPC_EXTRA = 2'b01,
        SPC_FUSE  = 2'b10,
        SPC_NONE  = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_PROG  = 2'd2
    } phase_e;

    // control register layout
    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             map_en;
        space_e           space;
    } ctrl_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } faddr_t;

    function automatic logic [7:0] cell_value(input logic erase, input logic [7:0] din);
        return erase ? 8'hFF : din;
    endfunction

endpackage

// File: rtl/fpp_key_ctrl.sv
module fpp_key_ctrl
    import fpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              busy,
    output logic              map_en,
    output logic              armed,
    output logic              launch,
    output space_e            launch_space
);

    ctrl_t req;
    logic  accept;

    assign req    = ctrl_t'(wr_data);
    assign accept = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_en <= 1'b0;
            armed  <= 1'b0;
        end else if (accept) begin
            map_en <= req.map_en;
            armed  <= (req.key == KEY_ARM);
        end
    end

    assign launch       = accept && armed && (req.key == KEY_FIRE) && (req.space != SPC_NONE);
    assign launch_space = req.space;

endmodule

// File: rtl/fpp_latch_buf.sv
module fpp_latch_buf
    import fpp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic                        clr,
    output logic [PAGE_BYTES-1:0]       ld_valid,
    output logic [PAGE_BYTES-1:0][7:0]  ld_data,
    output logic [PAGE_W-1:0]           ld_page
);

    faddr_t wa;
    assign wa = faddr_t'(wr_addr);

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        logic       hit;
        logic       v_q;
        logic [7:0] d_q;

        assign hit = wr_en && (wa.off == OFF_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= 8'h00;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (hit) begin
                v_q <= 1'b1;
                d_q <= wr_data;
            end
        end

        assign ld_valid[g] = v_q;
        assign ld_data[g]  = d_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_page <= '0;
        end else if (wr_en) begin
            ld_page <= wa.page;
        end
    end

endmodule

// File: rtl/fpp_seq.sv
module fpp_seq
    import fpp_pkg::*;
#(
    parameter int ERASE_CYCLES = 6,
    parameter int PROG_CYCLES  = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   launch,
    input  space_e launch_space,
    output logic   busy,
    output logic   erase_stb,
    output logic   prog_stb,
    output space_e tgt_space
);

    localparam int LONGEST = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            tgt_space <= SPC_NONE;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (launch) begin
                        phase_q   <= PH_ERASE;
                        cnt_q     <= CNT_W'(ERASE_CYCLES - 1);
                        tgt_space <= launch_space;
                    end
                end
                PH_ERASE: begin
                    if (last) begin
                        phase_q <= PH_PROG;
                        cnt_q   <= CNT_W'(PROG_CYCLES - 1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_PROG: begin
                    if (last) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase_q != PH_IDLE);
    assign erase_stb = (phase_q == PH_ERASE) && last;
    assign prog_stb  = (phase_q == PH_PROG) && last;

endmodule

// File: rtl/fpp_cell_array.sv
module fpp_cell_array
    import fpp_pkg::*;
#(
    parameter int         NUM_PAGES = 16,
    parameter logic [3:0] SEC_LOW   = 4'h3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       erase_stb,
    input  logic                       prog_stb,
    input  space_e                     tgt_space,
    input  logic [PAGE_W-1:0]          tgt_page,
    input  logic [PAGE_BYTES-1:0]      ld_valid,
    input  logic [PAGE_BYTES-1:0][7:0] ld_data,
    input  space_e                     rd_space,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data
);

    localparam int PIDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int UBYTES = NUM_PAGES * PAGE_BYTES;

    logic [7:0] user_q  [UBYTES];
    logic [7:0] extra_q [PAGE_BYTES];
    logic [3:0] fuse_hi_q;

    logic [PIDX_W-1:0] wr_pidx;
    logic [PIDX_W-1:0] rd_pidx;
    faddr_t            ra;

    assign ra      = faddr_t'(rd_addr);
    assign wr_pidx = PIDX_W'(int'(tgt_page) % NUM_PAGES);
    assign rd_pidx = PIDX_W'(int'(ra.page) % NUM_PAGES);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < UBYTES; i++) begin
                user_q[i] <= 8'hFF;
            end
            for (int i = 0; i < PAGE_BYTES; i++) begin
                extra_q[i] <= 8'hFF;
            end
            fuse_hi_q <= 4'hF;
        end else if (erase_stb || prog_stb) begin
            for (int b = 0; b < PAGE_BYTES; b++) begin
                if (ld_valid[b]) begin
                    case (tgt_space)
                        SPC_USER:  user_q[{wr_pidx, OFF_W'(b)}] <= cell_value(erase_stb, ld_data[b]);
                        SPC_EXTRA: extra_q[b] <= cell_value(erase_stb, ld_data[b]);
                        default: ;
                    endcase
                end
            end
            if ((tgt_space == SPC_FUSE) && ld_valid[0]) begin
                fuse_hi_q <= erase_stb ? 4'hF : ld_data[0][7:4];
            end
        end
    end

    always_comb begin
        case (rd_space)
            SPC_USER:  rd_data = user_q[{rd_pidx, ra.off}];
            SPC_EXTRA: rd_data = extra_q[ra.off];
            SPC_FUSE:  rd_data = {fuse_hi_q, SEC_LOW};
            default:   rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
    import fpp_pkg::*;
#(
    parameter int         NUM_PAGES    = 16,
    parameter int         ERASE_CYCLES = 6,
    parameter int         PROG_CYCLES  = 10,
    parameter logic [3:0] SEC_LOW      = 4'h3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTRL_W-1:0] ctl_wdata,
    input  logic              dat_we,
    input  logic [ADDR_W-1:0] dat_addr,
    input  logic [7:0]        dat_wdata,
    input  logic [1:0]        rd_space,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              idle_req
);

    logic                       map_en;
    logic                       key_armed;
    logic                       launch;
    space_e                     launch_space;
    logic                       erase_stb;
    logic                       prog_stb;
    space_e                     tgt_space;
    logic [PAGE_BYTES-1:0]      ld_valid;
    logic [PAGE_BYTES-1:0][7:0] ld_data;
    logic [PAGE_W-1:0]          ld_page;
    logic                       latch_we;

    fpp_key_ctrl key_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (ctl_we),
        .wr_data      (ctl_wdata),
        .busy         (busy),
        .map_en       (map_en),
        .armed        (key_armed),
        .launch       (launch),
        .launch_space (launch_space)
    );

    assign latch_we = dat_we && map_en && !busy;

    fpp_latch_buf latch_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (latch_we),
        .wr_addr  (dat_addr),
        .wr_data  (dat_wdata),
        .clr      (prog_stb),
        .ld_valid (ld_valid),
        .ld_data  (ld_data),
        .ld_page  (ld_page)
    );

    fpp_seq #(
        .ERASE_CYCLES (ERASE_CYCLES),
        .PROG_CYCLES  (PROG_CYCLES)
    ) seq_i (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .launch_space (launch_space),
        .busy         (busy),
        .erase_stb    (erase_stb),
        .prog_stb     (prog_stb),
        .tgt_space    (tgt_space)
    );

    fpp_cell_array #(
        .NUM_PAGES (NUM_PAGES),
        .SEC_LOW   (SEC_LOW)
    ) cells_i (
        .clk       (clk),
        .rst       (rst),
        .erase_stb (erase_stb),
        .prog_stb  (prog_stb),
        .tgt_space (tgt_space),
        .tgt_page  (ld_page),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data),
        .rd_space  (space_e'(rd_space)),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    assign idle_req = busy;

endmodule

// File: rtl/fpp_checker.sv
module fpp_checker
    import fpp_pkg::*;
#(
    parameter int ERASE_CYCLES = 6,
    parameter int PROG_CYCLES  = 10
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  busy,
    input logic                  ctl_we,
    input logic [KEY_W-1:0]      ctl_key,
    input logic [1:0]            ctl_mode,
    input logic                  dat_we,
    input logic                  key_armed,
    input logic                  map_en,
    input logic [PAGE_BYTES-1:0] ld_valid
);

    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end else begin
            run_cnt <= 0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !key_armed));

    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (dat_we && !map_en && !busy) |=> $stable(ld_valid));

    assert_launch_key_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(ctl_we) && ($past(ctl_key) == KEY_FIRE) && $past(key_armed)));

    assert_launch_mode_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(ctl_mode) != 2'b11));

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == ERASE_CYCLES + PROG_CYCLES));

    assert_valid_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (ld_valid == '0));

    assert_ctl_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && ctl_we) |=> ($stable(map_en) && $stable(key_armed)));

endmodule

bind flash_page_prog fpp_checker #(
    .ERASE_CYCLES (ERASE_CYCLES),
    .PROG_CYCLES  (PROG_CYCLES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .ctl_we    (ctl_we),
    .ctl_key   (ctl_wdata[6:3]),
    .ctl_mode  (ctl_wdata[1:0]),
    .dat_we    (dat_we),
    .key_armed (key_armed),
    .map_en    (map_en),
    .ld_valid  (ld_valid)
);

// File: tb/flash_page_prog_tb_top.sv
module flash_page_prog_tb_top;

    localparam int         NP = 16;
    localparam int         EC = 6;
    localparam int         PC = 10;
    localparam logic [3:0] SL = 4'h3;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [6:0]  ctl_wdata;
    logic        dat_we;
    logic [14:0] dat_addr;
    logic [7:0]  dat_wdata;
    logic [1:0]  rd_space;
    logic [14:0] rd_addr;
    logic [7:0]  rd_data;
    logic        busy;
    logic        idle_req;

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // behavioural reference state
    int um [NP*128];
    int xm [128];
    int fhi;
    int ld [128];
    bit lv [128];
    int lpage;
    bit armed_m, map_m, busy_m;
    int rem_m, sp_m;
    bit was_busy, was_map;
    int key_v, mode_v;

    always #4 clk = ~clk;

    flash_page_prog #(
        .NUM_PAGES    (NP),
        .ERASE_CYCLES (EC),
        .PROG_CYCLES  (PC),
        .SEC_LOW      (SL)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .dat_we    (dat_we),
        .dat_addr  (dat_addr),
        .dat_wdata (dat_wdata),
        .rd_space  (rd_space),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .idle_req  (idle_req)
    );

    function automatic int mread(int sp, int a);
        int pg = (a >> 7) % NP;
        int of = a & 127;
        case (sp)
            0: return um[pg*128 + of];
            1: return xm[of];
            2: return fhi * 16 + int'(SL);
            default: return 0;
        endcase
    endfunction

    task automatic apply(bit erase);
        for (int b = 0; b < 128; b++) begin
            if (lv[b]) begin
                if (sp_m == 0) um[(lpage % NP)*128 + b] = erase ? 255 : ld[b];
                else if (sp_m == 1) xm[b] = erase ? 255 : ld[b];
                else if (sp_m == 2 && b == 0) fhi = erase ? 15 : (ld[0] >> 4);
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NP*128; i++) um[i] = 255;
            for (int i = 0; i < 128; i++) begin xm[i] = 255; ld[i] = 0; lv[i] = 0; end
            fhi = 15; lpage = 0; armed_m = 0; map_m = 0; busy_m = 0; rem_m = 0; sp_m = 3;
        end else begin
            was_busy = busy_m;
            was_map  = map_m;
            if (busy_m) begin
                rem_m--;
                if (rem_m == PC) apply(1'b1);
                if (rem_m == 0) begin
                    apply(1'b0);
                    for (int i = 0; i < 128; i++) lv[i] = 0;
                    busy_m = 0;
                end
            end
            if (ctl_we && !was_busy) begin
                key_v  = int'(ctl_wdata[6:3]);
                mode_v = int'(ctl_wdata[1:0]);
                if (key_v == 10 && armed_m && mode_v != 3) begin
                    busy_m = 1; rem_m = EC + PC; sp_m = mode_v;
                end
                armed_m = (key_v == 5);
                map_m   = ctl_wdata[2];
            end
            if (dat_we && was_map && !was_busy) begin
                ld[int'(dat_addr[6:0])] = int'(dat_wdata);
                lv[int'(dat_addr[6:0])] = 1;
                lpage = int'(dat_addr[14:7]);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, 3 ns after each edge
    always begin
        @(posedge clk);
        #3;
        if (!rst && !finished) begin
            chk({cur_req, " busy"}, 32'(busy), 32'(busy_m));
            chk({cur_req, " idle_req"}, 32'(idle_req), 32'(busy_m));
            chk({cur_req, " rd_data"}, 32'(rd_data), 32'(mread(int'(rd_space), int'(rd_addr))));
        end
    end

    function automatic logic [14:0] fa(int pg, int of);
        return 15'(pg * 128 + of);
    endfunction

    task automatic ctl_wr(input logic [3:0] key, input logic map, input logic [1:0] mode);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = {key, map, mode};
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic dat_wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        dat_we = 1'b1; dat_addr = a; dat_wdata = d;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic launch(input logic [1:0] mode);
        ctl_wr(4'h5, 1'b1, mode);
        ctl_wr(4'hA, 1'b1, mode);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic pk(input string req, input logic [1:0] sp, input logic [14:0] a, input int exp);
        @(negedge clk);
        rd_space = sp; rd_addr = a;
        #1;
        chk(req, 32'(rd_data), 32'(exp));
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int n;
        rst = 1'b1; ctl_we = 0; ctl_wdata = '0; dat_we = 0; dat_addr = '0; dat_wdata = '0;
        rd_space = 2'b00; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 idle_req", 32'(idle_req), 0);
        pk("R1 main", 2'b00, fa(0, 0), 8'hFF);
        pk("R1 extra", 2'b01, fa(0, 127), 8'hFF);
        pk("R1 fuse", 2'b10, fa(0, 0), 8'hF3);

        // R2 / R5 / R7: ignored write with map clear, then a real page load
        cur_req = "R2";
        ctl_wr(4'h0, 1'b0, 2'b00);
        dat_wr(fa(2, 5), 8'h11);
        ctl_wr(4'h0, 1'b1, 2'b00);
        dat_wr(fa(2, 1), 8'hA1);
        dat_wr(fa(2, 2), 8'hA2);
        dat_wr(fa(2, 3), 8'hA3);
        cur_req = "R5";
        launch(2'b00);
        chk("R5 idle_req high", 32'(idle_req), 1);
        n = 0;
        while (busy) begin n++; @(posedge clk); #3; end
        chk("R5 busy length", 32'(n), 32'(EC + PC));
        pk("R2 map-off write dropped", 2'b00, fa(2, 5), 8'hFF);
        pk("R7 loaded byte", 2'b00, fa(2, 2), 8'hA2);
        pk("R7 other page", 2'b00, fa(1, 2), 8'hFF);

        // R6: erase-only window, then program
        cur_req = "R6";
        dat_wr(fa(2, 2), 8'h5A);
        launch(2'b00);
        repeat (EC) @(negedge clk);
        pk("R6 erased byte", 2'b00, fa(2, 2), 8'hFF);
        pk("R6 unloaded byte kept", 2'b00, fa(2, 3), 8'hA3);
        wait_idle();
        pk("R7 reprogrammed byte", 2'b00, fa(2, 2), 8'h5A);

        // R3: wrong key sequences
        cur_req = "R3";
        ctl_wr(4'h5, 1'b1, 2'b00);
        ctl_wr(4'h3, 1'b1, 2'b00);
        ctl_wr(4'hA, 1'b1, 2'b00);
        @(negedge clk);
        chk("R3 5-3-A no launch", 32'(busy), 0);
        ctl_wr(4'hA, 1'b1, 2'b00);
        @(negedge clk);
        chk("R3 lone A no launch", 32'(busy), 0);

        // R4: mode 11 does nothing, latches stay valid
        cur_req = "R4";
        dat_wr(fa(4, 0), 8'h44);
        launch(2'b11);
        @(negedge clk);
        chk("R4 no busy", 32'(busy), 0);
        pk("R4 untouched", 2'b00, fa(4, 0), 8'hFF);
        launch(2'b00);
        wait_idle();
        pk("R4 latch kept valid", 2'b00, fa(4, 0), 8'h44);

        // R8: last page wins, page field modulo
        cur_req = "R8";
        dat_wr(fa(3, 0), 8'h30);
        dat_wr(fa(7, 4), 8'h74);
        launch(2'b00);
        wait_idle();
        pk("R8 page 7 off 0", 2'b00, fa(7, 0), 8'h30);
        pk("R8 page 7 off 4", 2'b00, fa(7, 4), 8'h74);
        pk("R8 page 3 unchanged", 2'b00, fa(3, 0), 8'hFF);
        dat_wr(fa(21, 6), 8'h66);
        launch(2'b00);
        wait_idle();
        pk("R8 modulo page", 2'b00, fa(5, 6), 8'h66);

        // R9: extra row
        cur_req = "R9";
        dat_wr(fa(9, 9), 8'h77);
        launch(2'b01);
        wait_idle();
        pk("R9 extra row", 2'b01, fa(0, 9), 8'h77);
        pk("R9 main untouched", 2'b00, fa(9, 9), 8'hFF);

        // R10: security upper nibble only
        cur_req = "R10";
        dat_wr(fa(0, 0), 8'h2C);
        dat_wr(fa(0, 1), 8'h99);
        launch(2'b10);
        wait_idle();
        pk("R10 fuse", 2'b10, fa(0, 0), 8'h23);
        pk("R10 extra unaffected", 2'b01, fa(0, 1), 8'hFF);

        // R11: valid bits clear; last write wins
        cur_req = "R11";
        launch(2'b00);
        wait_idle();
        pk("R11 empty pass", 2'b00, fa(0, 0), 8'hFF);
        dat_wr(fa(6, 3), 8'h01);
        dat_wr(fa(6, 3), 8'h02);
        launch(2'b00);
        wait_idle();
        pk("R11 last value", 2'b00, fa(6, 3), 8'h02);

        // R12 / R2: control and data writes during busy
        cur_req = "R12";
        dat_wr(fa(8, 8), 8'h88);
        launch(2'b00);
        ctl_wr(4'h5, 1'b0, 2'b01);
        ctl_wr(4'hA, 1'b0, 2'b01);
        dat_wr(fa(8, 10), 8'hAA);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R12 no relaunch", 32'(busy), 0);
        pk("R12 mode kept", 2'b00, fa(8, 8), 8'h88);
        pk("R12 extra untouched", 2'b01, fa(0, 8), 8'hFF);
        dat_wr(fa(8, 9), 8'h89);
        launch(2'b00);
        wait_idle();
        pk("R12 map bit kept", 2'b00, fa(8, 9), 8'h89);
        pk("R2 busy write dropped", 2'b00, fa(8, 10), 8'hFF);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule